// File: doc/BRIEF.md
# Sliding-Window Quadrature Correlator

This block is the phase-detection front end of a digital locking loop. Each accepted signed sample of a digitised reference sine wave is multiplied by a locally generated cosine word and a locally generated sine word. The two products feed two correlation sums, the in-phase sum (I) and the quadrature sum (Q). A later stage turns the I/Q pair into a phase angle.

In the default sliding mode, the last `WIN` products are kept in a circular buffer. Each sum adds the newest product and removes the one that falls out of the window, so an overlapped result is produced for every accepted sample once the window has filled. A build-time variant instead integrates `WIN` products, emits one result per block and restarts from zero. Both variants share the multiplier stage and the output timing.

Top module: `quad_window_corr`

## Requirements
- R1: For every accepted sample, the I product is sample × cosine and the Q product is sample × sine. All three inputs are signed two's-complement `DW`-bit words, and each product is signed and `2*DW` bits wide.
- R2: In sliding mode, each result is the sum of the I (and the Q) products of the most recent `WIN` accepted samples, including the newest one.
- R3: The sums are `2*DW + clog2(WIN)` bits wide and signed. A full window of full-scale products, such as -32768 × -32768 repeated, is reported exactly, with no overflow.
- R4: In sliding mode, after reset `out_valid` stays low until the `WIN`-th accepted sample. It then asserts once for that sample and for every later accepted sample.
- R5: A result is due two register stages after its sample. If the sample is captured at rising edge k, the result and its `out_valid` appear just after edge k+1.
- R6: A cycle with `in_valid` low neither advances the window nor adds a product, and it produces no `out_valid` pulse.
- R7: In block mode (`MODE = CORR_DUMP`), `out_valid` pulses once per `WIN` accepted samples. Each result is the sum of that block's products only, and the next block starts from zero.
- R8: An active-low asynchronous reset clears both outputs to zero, drops `out_valid` and empties the window. The window then refills from scratch.
- R9: Between results (`out_valid` low), `out_i` and `out_q` hold their last reported values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample and reference words are valid this cycle |
| in_sample | input | DW | Signed sample of the reference sine wave |
| in_sin | input | DW | Signed local sine word |
| in_cos | input | DW | Signed local cosine word |
| out_valid | output | 1 | New I/Q result on the outputs |
| out_i | output | 2*DW+clog2(WIN) | Signed in-phase correlation sum |
| out_q | output | 2*DW+clog2(WIN) | Signed quadrature correlation sum |

## Verification
A result becomes due when the bench drives a sample before edge k. The bench then expects the result on the falling edge after edge k+1, which is two clock counts after the drive. The driver records that count alongside the expected I/Q values, and the monitor compares the count, the values and the presence of `out_valid` on each falling edge. On every cycle where no result is due, the monitor requires `out_valid` low and both sums unchanged. This covers idle gaps, the partial window after reset and the samples inside a block in block mode.

// File: rtl/corr_pkg.sv
package corr_pkg;
    typedef enum logic {
        CORR_SLIDE = 1'b0,
        CORR_DUMP  = 1'b1
    } corr_mode_e;
endpackage

// File: rtl/corr_mult.sv
module corr_mult #(
    parameter  int DW = 16,
    localparam int PW = 2 * DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] sample,
    input  logic signed [DW-1:0] sin_w,
    input  logic signed [DW-1:0] cos_w,
    output logic                 prod_valid,
    output logic signed [PW-1:0] prod_i,
    output logic signed [PW-1:0] prod_q
);
    typedef struct packed {
        logic                 vld;
        logic signed [PW-1:0] pi;
        logic signed [PW-1:0] pq;
    } mult_st_t;

    mult_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.pi = $signed(sample) * $signed(cos_w);
            st_d.pq = $signed(sample) * $signed(sin_w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prod_valid = st_q.vld;
    assign prod_i     = st_q.pi;
    assign prod_q     = st_q.pq;
endmodule

// File: rtl/corr_ring.sv
module corr_ring #(
    parameter  int PW  = 32,
    parameter  int WIN = 64,
    localparam int AW  = (WIN > 1) ? $clog2(WIN) : 1,
    localparam int FW  = $clog2(WIN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic signed [PW-1:0] wr_i,
    input  logic signed [PW-1:0] wr_q,
    output logic signed [PW-1:0] old_i,
    output logic signed [PW-1:0] old_q,
    output logic                 old_live,
    output logic                 win_full
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [FW-1:0] fill;
    } ring_st_t;

    ring_st_t st_d, st_q;
    logic [2*PW-1:0] mem [WIN];

    // Slot at the write pointer holds the product leaving the window.
    assign {old_i, old_q} = mem[st_q.ptr];
    assign old_live       = (st_q.fill == FW'(WIN));
    assign win_full       = (st_q.fill >= FW'(WIN - 1));

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ptr = (st_q.ptr == AW'(WIN - 1)) ? '0 : st_q.ptr + 1'b1;
            if (!old_live) st_d.fill = st_q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[st_q.ptr] <= {wr_i, wr_q};
    end

    p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fill <= FW'(WIN));

    p_live_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        old_live |=> old_live);
endmodule

// File: rtl/corr_accum.sv
module corr_accum
    import corr_pkg::*;
#(
    parameter  int         PW   = 32,
    parameter  int         WIN  = 64,
    parameter  corr_mode_e MODE = CORR_SLIDE,
    localparam int         SW   = PW + $clog2(WIN),
    localparam int         CW   = (WIN > 1) ? $clog2(WIN) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 prod_valid,
    input  logic signed [PW-1:0] prod_i,
    input  logic signed [PW-1:0] prod_q,
    input  logic signed [PW-1:0] old_i,
    input  logic signed [PW-1:0] old_q,
    input  logic                 old_live,
    input  logic                 win_full,
    output logic                 out_valid,
    output logic signed [SW-1:0] out_i,
    output logic signed [SW-1:0] out_q
);
    typedef struct packed {
        logic                 vld;
        logic signed [SW-1:0] si;
        logic signed [SW-1:0] sq;
        logic signed [SW-1:0] oi;
        logic signed [SW-1:0] oq;
        logic [CW-1:0]        cnt;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic signed [SW-1:0] new_pi, new_pq;

    assign new_pi = SW'(prod_i);
    assign new_pq = SW'(prod_q);

    generate
        if (MODE == CORR_SLIDE) begin : g_slide
            logic signed [SW-1:0] drop_i, drop_q, nxt_i, nxt_q;
            always_comb begin
                st_d     = st_q;
                st_d.vld = 1'b0;
                drop_i   = '0;
                drop_q   = '0;
                if (old_live) begin
                    drop_i = SW'(old_i);
                    drop_q = SW'(old_q);
                end
                nxt_i = st_q.si + new_pi - drop_i;
                nxt_q = st_q.sq + new_pq - drop_q;
                if (prod_valid) begin
                    st_d.si = nxt_i;
                    st_d.sq = nxt_q;
                    if (win_full) begin
                        st_d.oi  = nxt_i;
                        st_d.oq  = nxt_q;
                        st_d.vld = 1'b1;
                    end
                end
            end
        end else begin : g_dump
            always_comb begin
                st_d     = st_q;
                st_d.vld = 1'b0;
                if (prod_valid) begin
                    if (st_q.cnt == CW'(WIN - 1)) begin
                        st_d.oi  = st_q.si + new_pi;
                        st_d.oq  = st_q.sq + new_pq;
                        st_d.si  = '0;
                        st_d.sq  = '0;
                        st_d.cnt = '0;
                        st_d.vld = 1'b1;
                    end else begin
                        st_d.si  = st_q.si + new_pi;
                        st_d.sq  = st_q.sq + new_pq;
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end

            p_block_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.vld |=> !st_q.vld);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_i     = st_q.oi;
    assign out_q     = st_q.oq;

    localparam longint LIM = longint'(WIN) <<< (PW - 2);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'(st_q.si) <= LIM) && (longint'(st_q.si) >= -LIM) &&
        (longint'(st_q.sq) <= LIM) && (longint'(st_q.sq) >= -LIM));
endmodule

// File: rtl/quad_window_corr.sv
module quad_window_corr
    import corr_pkg::*;
#(
    parameter  int         DW   = 16,
    parameter  int         WIN  = 64,
    parameter  corr_mode_e MODE = CORR_SLIDE,
    localparam int         PW   = 2 * DW,
    localparam int         SW   = PW + $clog2(WIN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_sample,
    input  logic signed [DW-1:0] in_sin,
    input  logic signed [DW-1:0] in_cos,
    output logic                 out_valid,
    output logic signed [SW-1:0] out_i,
    output logic signed [SW-1:0] out_q
);
    logic                 prod_valid;
    logic signed [PW-1:0] prod_i, prod_q;
    logic signed [PW-1:0] old_i, old_q;
    logic                 old_live, win_full;

    corr_mult #(.DW(DW)) u_mult (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .sample    (in_sample),
        .sin_w     (in_sin),
        .cos_w     (in_cos),
        .prod_valid(prod_valid),
        .prod_i    (prod_i),
        .prod_q    (prod_q)
    );

    generate
        if (MODE == CORR_SLIDE) begin : g_ring
            corr_ring #(.PW(PW), .WIN(WIN)) u_ring (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (prod_valid),
                .wr_i    (prod_i),
                .wr_q    (prod_q),
                .old_i   (old_i),
                .old_q   (old_q),
                .old_live(old_live),
                .win_full(win_full)
            );
        end else begin : g_no_ring
            assign old_i    = '0;
            assign old_q    = '0;
            assign old_live = 1'b0;
            assign win_full = 1'b0;
        end
    endgenerate

    corr_accum #(.PW(PW), .WIN(WIN), .MODE(MODE)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .prod_valid(prod_valid),
        .prod_i    (prod_i),
        .prod_q    (prod_q),
        .old_i     (old_i),
        .old_q     (old_q),
        .old_live  (old_live),
        .win_full  (win_full),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_i) && $stable(out_q)));
endmodule

// File: tb/quad_window_corr_bench.sv
module quad_window_corr_bench;
    import corr_pkg::*;

    localparam int DW  = 16;
    localparam int WIN = 8;
    localparam int PW  = 2 * DW;
    localparam int SW  = PW + $clog2(WIN);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] smp = '0, sn = '0, cs = '0;
    logic                 s_vld, d_vld;
    logic signed [SW-1:0] s_i, s_q, d_i, d_q;

    quad_window_corr #(.DW(DW), .WIN(WIN), .MODE(CORR_SLIDE)) u_quad_window_corr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(smp),
        .in_sin(sn), .in_cos(cs), .out_valid(s_vld), .out_i(s_i), .out_q(s_q)
    );

    quad_window_corr #(.DW(DW), .WIN(WIN), .MODE(CORR_DUMP)) u_quad_window_corr_dump (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(smp),
        .in_sin(sn), .in_cos(cs), .out_valid(d_vld), .out_i(d_i), .out_q(d_q)
    );

    typedef struct {
        longint due;
        longint ei;
        longint eq;
    } exp_t;

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    bit     done = 1'b0;
    exp_t   sq_s[$], sq_d[$];
    longint hist_i[$], hist_q[$];
    longint dacc_i = 0, dacc_q = 0;
    int     dcnt = 0;
    longint last_si = 0, last_sq = 0, last_di = 0, last_dq = 0;
    logic [31:0] rng = 32'h1234_5678;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: presents one cycle of input and pushes the expected results.
    task automatic drive(input bit v, input int s, input int si, input int co);
        longint pi, pq, ti, tq;
        @(negedge clk);
        in_valid = v;
        smp = DW'(s);
        sn  = DW'(si);
        cs  = DW'(co);
        if (v) begin
            pi = longint'(s) * longint'(co);
            pq = longint'(s) * longint'(si);
            hist_i.push_back(pi);
            hist_q.push_back(pq);
            if (hist_i.size() > WIN) begin
                void'(hist_i.pop_front());
                void'(hist_q.pop_front());
            end
            if (hist_i.size() == WIN) begin
                ti = 0; tq = 0;
                foreach (hist_i[k]) begin
                    ti += hist_i[k];
                    tq += hist_q[k];
                end
                sq_s.push_back('{cyc + 2, ti, tq});
            end
            dacc_i += pi;
            dacc_q += pq;
            dcnt++;
            if (dcnt == WIN) begin
                sq_d.push_back('{cyc + 2, dacc_i, dacc_q});
                dacc_i = 0; dacc_q = 0; dcnt = 0;
            end
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        hist_i.delete(); hist_q.delete();
        sq_s.delete();   sq_d.delete();
        dacc_i = 0; dacc_q = 0; dcnt = 0;
        last_si = 0; last_sq = 0; last_di = 0; last_dq = 0;
        // R8: outputs cleared while reset is held
        check(s_vld == 1'b0 && d_vld == 1'b0, "R8", "valid in reset", longint'(s_vld | d_vld), 0);
        check(s_i == '0 && s_q == '0, "R8", "sliding sums in reset", longint'(s_i), 0);
        check(d_i == '0 && d_q == '0, "R8", "block sums in reset", longint'(d_i), 0);
        rst_n = 1'b1;
    endtask

    function automatic int next_word();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return int'($signed(rng[15:0]));
    endfunction

    // Monitor: compares outputs against the scoreboard on falling edges.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && !done) begin
            if (sq_s.size() != 0 && sq_s[0].due < cyc) begin
                e = sq_s.pop_front();
                check(1'b0, "R5", "sliding result missing at due cycle", cyc, e.due);
            end
            if (s_vld) begin
                if (sq_s.size() == 0) begin
                    check(1'b0, "R4", "sliding valid with nothing due", 1, 0);
                end else begin
                    e = sq_s.pop_front();
                    check(e.due == cyc, "R5", "sliding result cycle", cyc, e.due);
                    check(longint'(s_i) == e.ei, "R2", "sliding I sum (sample x cos)", longint'(s_i), e.ei);
                    check(longint'(s_q) == e.eq, "R2", "sliding Q sum (sample x sin)", longint'(s_q), e.eq);
                end
                last_si = longint'(s_i);
                last_sq = longint'(s_q);
            end else begin
                check(longint'(s_i) == last_si && longint'(s_q) == last_sq,
                      "R9", "sliding output hold", longint'(s_i), last_si);
            end
            if (sq_d.size() != 0 && sq_d[0].due < cyc) begin
                e = sq_d.pop_front();
                check(1'b0, "R7", "block result missing at due cycle", cyc, e.due);
            end
            if (d_vld) begin
                if (sq_d.size() == 0) begin
                    check(1'b0, "R7", "block valid with nothing due", 1, 0);
                end else begin
                    e = sq_d.pop_front();
                    check(e.due == cyc, "R5", "block result cycle", cyc, e.due);
                    check(longint'(d_i) == e.ei, "R7", "block I sum", longint'(d_i), e.ei);
                    check(longint'(d_q) == e.eq, "R7", "block Q sum", longint'(d_q), e.eq);
                end
                last_di = longint'(d_i);
                last_dq = longint'(d_q);
            end else begin
                check(longint'(d_i) == last_di && longint'(d_q) == last_dq,
                      "R9", "block output hold", longint'(d_i), last_di);
            end
        end
    end

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired at cycle %0d (expected completion)", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        apply_reset();

        // R1/R2/R4: continuous ramp with distinct sine and cosine words
        for (int n = 0; n < 20; n++) drive(1'b1, 100 * n - 700, 3 * n + 11, -5 * n + 40);

        // R6: gaps between accepted samples
        for (int n = 0; n < 24; n++) begin
            drive(1'b1, 1000 - 90 * n, -200 + 17 * n, 250 - 9 * n);
            drive(1'b0, 12345, 321, -321);
            if (n % 3 == 0) drive(1'b0, -999, 777, 555);
        end

        // R3: full-scale windows
        for (int n = 0; n < WIN + 3; n++) drive(1'b1, -32768, -32768, -32768);
        for (int n = 0; n < WIN + 3; n++) drive(1'b1, 32767, -32768, 32767);

        // R8: reset with a partly filled window, then refill
        for (int n = 0; n < 5; n++) drive(1'b1, 3000, 2000, -1000);
        apply_reset();
        for (int n = 0; n < 2 * WIN + 2; n++) drive(1'b1, 50 * n - 400, 123, -77 + n);

        // R1/R2/R6/R7: pseudo-random words with random gaps
        for (int n = 0; n < 300; n++) begin
            int a, b, c;
            a = next_word();
            b = next_word();
            c = next_word();
            drive(rng[3:0] != 4'd0, a, b, c);
        end

        drive(1'b0, 0, 0, 0);
        repeat (4) @(negedge clk);
        check(sq_s.size() == 0, "R4", "sliding results outstanding", sq_s.size(), 0);
        check(sq_d.size() == 0, "R7", "block results outstanding", sq_d.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule